// File: doc/BRIEF.md
# Debug Link Mode-Switch Sequencer

This block sits on the host side of a two-wire debug link. It produces the fixed bit streams that reset the link or move the target between its serial-wire mode, its boundary-scan (JTAG) mode and its low-power dormant state. A three-bit selector picks one of seven streams. A one-cycle start pulse launches the selected stream. While the stream plays, `busy` is high. A one-cycle `done` pulse marks its end.

The block does not divide the clock. A clock-enable `tick` from outside sets the pace, and each tick moves the debug clock half a period. One bit therefore takes two ticks. The data line changes only as the debug clock falls, so it is steady when the target samples on the rising edge. Within each stored code, the least significant bit goes out first. The length of the long all-high runs and of the trailing idle run are parameters. The values given in the requirements below are the defaults.

Top module: `dbg_switch_seq`

## Requirements
- R1: After reset, and whenever no stream is playing, `busy`, `done`, `dclk`, `dio` and `dio_oe` are all 0.
- R2: A `start` pulse with `sel` in 0..6 while idle takes effect on the next clock edge. From that edge `busy` and `dio_oe` are 1, `dclk` is 0 and `dio` carries bit 0 of the stream. `dio_oe` stays 1 until the last bit is complete.
- R3: While busy, every `tick` toggles `dclk` and nothing else does. `dio` changes only on the edge where `dclk` falls, so it holds steady during each high phase. Exactly one stream bit goes out per `dclk` period.
- R4: Every code word is sent least significant bit first. A multi-byte code sends byte 0 first.
- R5: `sel`=0 (line reset) sends 56 ones, then 8 zeros: 64 bits.
- R6: `sel`=1 (JTAG to serial-wire) sends 56 ones, the 16-bit code 0xE79E, 56 ones, then 8 zeros: 136 bits.
- R7: `sel`=2 (serial-wire to JTAG) sends 56 ones, the 16-bit code 0xE73C, then 8 ones: 80 bits.
- R8: `sel`=3 (serial-wire to dormant) sends 56 ones, then the 16-bit code 0xE3BC: 72 bits.
- R9: `sel`=4 (dormant to serial-wire) sends 224 bits, in this order:
  - 8 ones;
  - the 128-bit alert, whose bytes 0 to 15 are 92 F3 09 62 95 2D 85 86 E9 AF DD E3 A2 0E BC 19;
  - 4 zeros;
  - the 8-bit code 0x1A;
  - 12 ones;
  - 56 ones;
  - 8 zeros.
- R10: `sel`=5 (JTAG to dormant) sends 9 ones, then the 31-bit code 0x33BBBBBA: 40 bits.
- R11: `sel`=6 (dormant to JTAG) sends 160 bits, in this order:
  - 8 ones;
  - the same 128-bit alert;
  - 4 zeros;
  - a 12-bit all-zero activation code;
  - 8 zeros.
- R12: On the edge where `dclk` falls after the last bit's high phase, `busy`, `dio_oe`, `dio` and `dclk` go to 0 and `done` rises. `done` lasts exactly one cycle, and there is one `done` per stream.
- R13: A `start` while busy has no effect on the stream in progress. A `start` with `sel`=7 is ignored: `busy` stays 0 and no `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Clock enable; each one is half a debug-clock period |
| start | input | 1 | Launch request, one cycle |
| sel | input | 3 | Stream selector (0..6 valid, 7 unused) |
| busy | output | 1 | A stream is playing |
| done | output | 1 | One-cycle pulse at the end of a stream |
| dclk | output | 1 | Debug clock to the target |
| dio | output | 1 | Data / mode line value |
| dio_oe | output | 1 | Output enable for the data line |

## Verification
The bench plays every stream at two tick rates and compares the full captured bit string, along with its length, against a string it builds from the segment lists above. An off-by-one segment boundary or a missing final bit would therefore show up as a wrong length or a shifted bit. A design that sent codes MSB first, or read the alert bytes in reverse order, would corrupt the alert, the activation code or the switch codes, and the content check reports this. At each `dclk` rise, the bench watches for data moving while the clock is high and for clock toggles without a tick, so an update on the wrong phase is caught. A start issued mid-stream with another selector, and a start with the unused selector, are each caught if the design restarts, changes the stream, or raises `busy` for the unused selector.

// File: rtl/swseq_pkg.sv
// Shared constants for the debug-link mode-switch sequencer.
// Assumes all codes are stored as little-endian bit vectors: bit 0 is sent first.
package swseq_pkg;

    typedef enum logic [2:0] {
        SQ_LINE_RST = 3'd0,
        SQ_J2S      = 3'd1,
        SQ_S2J      = 3'd2,
        SQ_S2D      = 3'd3,
        SQ_D2S      = 3'd4,
        SQ_J2D      = 3'd5,
        SQ_D2J      = 3'd6,
        SQ_NONE     = 3'd7
    } seq_sel_e;

    // Fixed segment sizes of the streams
    localparam int unsigned ALERT_BITS       = 128;
    localparam int unsigned SW_CODE_BITS     = 16;
    localparam int unsigned J2D_CODE_BITS    = 31;
    localparam int unsigned ACT_SWD_BITS     = 8;
    localparam int unsigned ACT_JTAG_BITS    = 12;
    localparam int unsigned GAP_LO_BITS      = 4;
    localparam int unsigned PRE_HI_BITS      = 8;
    localparam int unsigned J2D_PRE_BITS     = 9;
    localparam int unsigned TLR_HI_BITS      = 8;
    localparam int unsigned ACT_TAIL_HI_BITS = 12;
    localparam int unsigned PARK_LO_BITS     = 8;

    // Code words, bit 0 first on the wire
    localparam logic [127:0] ALERT_PAT = 128'h19BC_0EA2_E3DD_AFE9_8685_2D95_6209_F392;
    localparam logic [127:0] J2S_PAT   = 128'hE79E;
    localparam logic [127:0] S2J_PAT   = 128'hE73C;
    localparam logic [127:0] S2D_PAT   = 128'hE3BC;
    localparam logic [127:0] J2D_PAT   = 128'h33BB_BBBA;
    localparam logic [127:0] ACT_PAT   = 128'h1A;

    // Returns bit k of a stored code word
    function automatic logic pat_bit(input logic [127:0] v, input int unsigned k);
        return 1'(v >> k);
    endfunction

endpackage

// File: rtl/swseq_pattern.sv
// Stream pattern lookup: maps (selector, bit position) to the line value and
// reports the index of the final bit of the selected stream.
// Assumes idx never exceeds the reported last index; purely combinational.
module swseq_pattern
    import swseq_pkg::*;
#(
    parameter int unsigned HI_RUN = 56,
    parameter int unsigned LO_RUN = 8,
    parameter int          IW     = 8
) (
    input  seq_sel_e        sel,
    input  logic [IW-1:0]   idx,
    output logic            bit_o,
    output logic [IW-1:0]   last_idx
);

    // Segment boundaries (exclusive end positions)
    localparam int unsigned LR_LEN    = HI_RUN + LO_RUN;
    localparam int unsigned SC_END    = HI_RUN + SW_CODE_BITS;
    localparam int unsigned J2S_HI2   = SC_END + HI_RUN;
    localparam int unsigned J2S_LEN   = J2S_HI2 + LO_RUN;
    localparam int unsigned S2J_LEN   = SC_END + TLR_HI_BITS;
    localparam int unsigned S2D_LEN   = SC_END;
    localparam int unsigned AL_END    = PRE_HI_BITS + ALERT_BITS;
    localparam int unsigned GAP_END   = AL_END + GAP_LO_BITS;
    localparam int unsigned ACT_END   = GAP_END + ACT_SWD_BITS;
    localparam int unsigned TAIL_END  = ACT_END + ACT_TAIL_HI_BITS;
    localparam int unsigned D2S_HIEND = TAIL_END + HI_RUN;
    localparam int unsigned D2S_LEN   = D2S_HIEND + LO_RUN;
    localparam int unsigned J2D_LEN   = J2D_PRE_BITS + J2D_CODE_BITS;
    localparam int unsigned D2J_LEN   = GAP_END + ACT_JTAG_BITS + PARK_LO_BITS;

    int unsigned pos;
    int unsigned total;

    // Decode the current bit and stream length from the selector
    always_comb begin
        pos   = 32'(idx);
        bit_o = 1'b0;
        total = 1;
        case (sel)
            SQ_LINE_RST: begin
                total = LR_LEN;
                bit_o = (pos < HI_RUN);
            end
            SQ_J2S: begin
                total = J2S_LEN;
                if (pos < HI_RUN)       bit_o = 1'b1;
                else if (pos < SC_END)  bit_o = pat_bit(J2S_PAT, pos - HI_RUN);
                else if (pos < J2S_HI2) bit_o = 1'b1;
                else                    bit_o = 1'b0;
            end
            SQ_S2J: begin
                total = S2J_LEN;
                if (pos < HI_RUN)      bit_o = 1'b1;
                else if (pos < SC_END) bit_o = pat_bit(S2J_PAT, pos - HI_RUN);
                else                   bit_o = 1'b1;
            end
            SQ_S2D: begin
                total = S2D_LEN;
                if (pos < HI_RUN) bit_o = 1'b1;
                else              bit_o = pat_bit(S2D_PAT, pos - HI_RUN);
            end
            SQ_D2S: begin
                total = D2S_LEN;
                if (pos < PRE_HI_BITS)    bit_o = 1'b1;
                else if (pos < AL_END)    bit_o = pat_bit(ALERT_PAT, pos - PRE_HI_BITS);
                else if (pos < GAP_END)   bit_o = 1'b0;
                else if (pos < ACT_END)   bit_o = pat_bit(ACT_PAT, pos - GAP_END);
                else if (pos < D2S_HIEND) bit_o = 1'b1;
                else                      bit_o = 1'b0;
            end
            SQ_J2D: begin
                total = J2D_LEN;
                if (pos < J2D_PRE_BITS) bit_o = 1'b1;
                else                    bit_o = pat_bit(J2D_PAT, pos - J2D_PRE_BITS);
            end
            SQ_D2J: begin
                total = D2J_LEN;
                if (pos < PRE_HI_BITS) bit_o = 1'b1;
                else if (pos < AL_END) bit_o = pat_bit(ALERT_PAT, pos - PRE_HI_BITS);
                else                   bit_o = 1'b0;
            end
            default: begin
                total = 1;
                bit_o = 1'b0;
            end
        endcase
    end

    assign last_idx = IW'(total - 1);

endmodule

// File: rtl/swseq_pacer.sv
// Bit pacer: owns the debug clock phase, the bit index and the busy/done flags.
// Assumes tick is a one-cycle clock enable; each tick is half a debug-clock period.
module swseq_pacer #(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic          sel_ok,
    input  logic [IW-1:0] last_idx,
    output logic          accept,
    output logic          busy,
    output logic          dclk,
    output logic          done,
    output logic [IW-1:0] idx
);

    // A launch is taken only when idle and the selector names a stream
    assign accept = start & sel_ok & ~busy;

    // Advance clock phase on each tick; step the index when the clock falls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            dclk <= 1'b0;
            done <= 1'b0;
            idx  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy <= 1'b1;
                dclk <= 1'b0;
                idx  <= '0;
            end else if (busy && tick) begin
                if (!dclk) begin
                    dclk <= 1'b1;
                end else begin
                    dclk <= 1'b0;
                    if (idx == last_idx) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        idx  <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dbg_switch_seq.sv
// Debug-link mode-switch sequencer top: latches the selector at launch and
// drives clock, data and output-enable from the pacer and the pattern lookup.
// Assumes sel is only sampled on an accepted start; outputs are idle-low.
module dbg_switch_seq
    import swseq_pkg::*;
#(
    parameter int unsigned HI_RUN = 56,
    parameter int unsigned LO_RUN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic [2:0] sel,
    output logic       busy,
    output logic       done,
    output logic       dclk,
    output logic       dio,
    output logic       dio_oe
);

    localparam int unsigned LEN_D2S = PRE_HI_BITS + ALERT_BITS + GAP_LO_BITS + ACT_SWD_BITS
                                      + ACT_TAIL_HI_BITS + HI_RUN + LO_RUN;
    localparam int unsigned LEN_J2S = 2 * HI_RUN + SW_CODE_BITS + LO_RUN;
    localparam int unsigned MAXLEN  = (LEN_D2S > LEN_J2S) ? LEN_D2S : LEN_J2S;
    localparam int          IW      = $clog2(MAXLEN);

    seq_sel_e      sel_q;
    logic          accept;
    logic          sel_ok;
    logic          pat_out;
    logic [IW-1:0] idx;
    logic [IW-1:0] last_idx;

    assign sel_ok = (seq_sel_e'(sel) != SQ_NONE);

    // Hold the selector for the whole stream
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= SQ_LINE_RST;
        else if (accept) sel_q <= seq_sel_e'(sel);
    end

    swseq_pacer #(.IW(IW)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (start),
        .sel_ok   (sel_ok),
        .last_idx (last_idx),
        .accept   (accept),
        .busy     (busy),
        .dclk     (dclk),
        .done     (done),
        .idx      (idx)
    );

    swseq_pattern #(.HI_RUN(HI_RUN), .LO_RUN(LO_RUN), .IW(IW)) u_pattern (
        .sel      (sel_q),
        .idx      (idx),
        .bit_o    (pat_out),
        .last_idx (last_idx)
    );

    assign dio    = busy & pat_out;
    assign dio_oe = busy;

endmodule

// File: rtl/swseq_chk.sv
// Protocol checker for the mode-switch sequencer, bound to the top module.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module swseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       start,
    input logic [2:0] sel,
    input logic       busy,
    input logic       done,
    input logic       dclk,
    input logic       dio,
    input logic       dio_oe
);

    // R3
    dio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk && $past(dclk)) |-> $stable(dio));

    // R3
    clk_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(dclk));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!dio && !dio_oe && !dclk));

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R13
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && sel == 3'd7) |=> !busy);

    // R13
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dclk && start && !tick) |=> dclk);

endmodule

bind dbg_switch_seq swseq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .start  (start),
    .sel    (sel),
    .busy   (busy),
    .done   (done),
    .dclk   (dclk),
    .dio    (dio),
    .dio_oe (dio_oe)
);

// File: tb/sim_dbg_switch_seq.sv
// Bench: plays every stream at several tick rates and compares captured bits
// against streams assembled from the requirement segment lists.
module sim_dbg_switch_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       start = 1'b0;
    logic [2:0] sel_in = 3'd0;
    logic       busy, done, dclk, dio, dio_oe;

    int n_chk = 0;
    int n_fail = 0;
    int tick_div = 1;
    int tcnt = 0;

    logic exp_bits [0:255];
    int   exp_n;
    logic cap [0:255];
    int   cap_n = 0;
    int   stab_err = 0, tog_err = 0, oe_err = 0;
    int   done_cnt = 0, done_wide = 0, end_err = 0;
    logic prev_dclk = 1'b0, prev_done = 1'b0, hold = 1'b0;

    logic [7:0] alert_b [16] = '{8'h92, 8'hF3, 8'h09, 8'h62, 8'h95, 8'h2D, 8'h85, 8'h86,
                                 8'hE9, 8'hAF, 8'hDD, 8'hE3, 8'hA2, 8'h0E, 8'hBC, 8'h19};

    always #5 clk = ~clk;

    dbg_switch_seq u0 (
        .clk (clk), .rst_n (rst_n), .tick (tick), .start (start), .sel (sel_in),
        .busy (busy), .done (done), .dclk (dclk), .dio (dio), .dio_oe (dio_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic exp_run(input logic v, input int n);
        for (int k = 0; k < n; k++) begin exp_bits[exp_n] = v; exp_n++; end
    endtask

    task automatic exp_word(input logic [31:0] w, input int n);
        for (int k = 0; k < n; k++) begin exp_bits[exp_n] = w[k]; exp_n++; end
    endtask

    task automatic exp_alert();
        for (int b = 0; b < 16; b++) exp_word({24'd0, alert_b[b]}, 8);
    endtask

    task automatic build_exp(input int s);
        exp_n = 0;
        case (s)
            0: begin exp_run(1, 56); exp_run(0, 8); end
            1: begin exp_run(1, 56); exp_word(32'hE79E, 16); exp_run(1, 56); exp_run(0, 8); end
            2: begin exp_run(1, 56); exp_word(32'hE73C, 16); exp_run(1, 8); end
            3: begin exp_run(1, 56); exp_word(32'hE3BC, 16); end
            4: begin exp_run(1, 8); exp_alert(); exp_run(0, 4); exp_word(32'h1A, 8);
                     exp_run(1, 12); exp_run(1, 56); exp_run(0, 8); end
            5: begin exp_run(1, 9); exp_word(32'h33BBBBBA, 31); end
            default: begin exp_run(1, 8); exp_alert(); exp_run(0, 4); exp_run(0, 12); exp_run(0, 8); end
        endcase
    endtask

    function automatic string req_of(input int s);
        case (s)
            0: return "R5"; 1: return "R6"; 2: return "R7"; 3: return "R8";
            4: return "R9"; 5: return "R10"; default: return "R11";
        endcase
    endfunction

    // Output monitor, then tick generation, once per falling system-clock edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (dclk && !prev_dclk) begin
                    if (cap_n < 256) cap[cap_n] = dio;
                    cap_n++;
                    hold = dio;
                end else if (dclk && prev_dclk && dio !== hold) begin
                    stab_err++;
                end
                if (dclk !== prev_dclk && !tick) tog_err++;
                if (busy && !dio_oe) oe_err++;
                if (done) begin
                    done_cnt++;
                    if (prev_done) done_wide++;
                    if (busy || dio_oe || dio || dclk) end_err++;
                end
            end
            prev_dclk = dclk;
            prev_done = done;
            if (tcnt >= tick_div - 1) begin tick = 1'b1; tcnt = 0; end
            else begin tick = 1'b0; tcnt++; end
        end
    end

    task automatic run_seq(input int s, input int div, input bit interfere);
        int mism;
        string rq;
        rq = req_of(s);
        build_exp(s);
        tick_div = div;
        @(negedge clk);
        cap_n = 0; stab_err = 0; tog_err = 0; oe_err = 0;
        done_cnt = 0; done_wide = 0; end_err = 0;
        sel_in = 3'(s);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1 && dio_oe === 1'b1 && dclk === 1'b0, "R2 launch state",
              int'({busy, dio_oe, dclk}), 6);
        check(dio === exp_bits[0], "R2 first bit", int'(dio), int'(exp_bits[0]));
        if (interfere) begin
            repeat (7) @(negedge clk);
            sel_in = 3'((s + 2) % 7);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        repeat (4 * div + 4) @(negedge clk);
        mism = 0;
        for (int k = 0; k < exp_n; k++)
            if (k >= cap_n || cap[k] !== exp_bits[k]) mism++;
        check(cap_n == exp_n, {rq, " length"}, cap_n, exp_n);
        check(mism == 0, {rq, " R4 bit content", interfere ? " R13 busy start" : ""}, mism, 0);
        check(stab_err == 0 && tog_err == 0, "R3 clock/data phase", stab_err + tog_err, 0);
        check(oe_err == 0, "R2 oe held", oe_err, 0);
        check(done_cnt == 1 && done_wide == 0, "R12 done pulse", done_cnt + done_wide, 1);
        check(end_err == 0, "R12 end state", end_err, 0);
        check(busy === 1'b0 && dio_oe === 1'b0 && dio === 1'b0, "R1 idle after", int'({busy, dio_oe, dio}), 0);
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check({busy, done, dclk, dio, dio_oe} === 5'b0, "R1 reset state",
              int'({busy, done, dclk, dio, dio_oe}), 0);
        for (int d = 1; d <= 3; d += 2)
            for (int s = 0; s < 7; s++) run_seq(s, d, 1'b0);
        run_seq(1, 2, 1'b1);
        run_seq(4, 2, 1'b1);
        run_seq(6, 1, 1'b1);
        // R13 unused selector is ignored
        done_cnt = 0;
        @(negedge clk);
        sel_in = 3'd7;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        check(busy === 1'b0 && dio_oe === 1'b0 && dclk === 1'b0 && done_cnt == 0,
              "R13 sel 7 ignored", int'({busy, dio_oe, dclk}) + done_cnt, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule